// File: doc/BRIEF.md
# Iterative Factorial Engine

This block computes the factorial of an unsigned operand over many clock cycles. It keeps a single arithmetic unit that can either multiply or subtract. A small controller sequences that unit. On each pass of the loop, the accumulator is multiplied by the counter, and then the counter is decremented by one. The controller then tests whether the counter has reached one.

A caller places the operand on `n` and pulses `start`. Some cycles later `done` rises, and `result` carries the factorial truncated to the datapath width. The flag and the value stay put until the next accepted `start`. A `start` that arrives while a computation is running is dropped.

Top module: `fact_engine`

## Requirements
- R1: With the default width of 32, `result` equals n! modulo 2^32 whenever `done` is high after a computation.
- R2: While `rstN` is low and just after it is released, `done` is 0 and `result` is 0.
- R3: A `start` accepted while idle or finished loads the accumulator with 1 and the counter with `n`, in the same clock edge.
- R4: An operand of 0 or 1 finishes with `result` = 1.
- R5: The controller runs multiply, then subtract, then compare, and returns to multiply only while the counter is above 1.
- R6: The operation select is 1 for subtraction and 0 for multiplication. Subtraction takes the counter and the constant 1 and writes the counter. Multiplication takes the accumulator and the counter and writes the accumulator.
- R7: Once `done` is high, it stays high and `result` holds still until the next `start`.
- R8: A `start` pulse during a computation has no effect on its result or its latency.
- R9: Operands above 12 wrap without any flag; for example, 13 gives 1932053504.
- R10: An operand of 5 yields 120.
- R11: `done` is first seen high 3n-1 clock edges after the edge that accepts `start`, counting that edge, for n >= 1, and 2 edges after it for n = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a computation; taken only when idle or finished |
| n | input | 32 | Unsigned operand |
| result | output | 32 | Accumulator value; the factorial once `done` is high |
| done | output | 1 | High from completion until the next accepted start |

## Verification
On every cycle, the embedded assertions check the following:
- the state order multiply, subtract, compare;
- the exit from compare back to multiply while the counter exceeds one;
- the load values taken at an accepted start;
- the decrement by exactly one in the subtract step;
- that `done` and `result` hold still while no start arrives.

Other properties show only in the bench's scenarios:
- the arithmetic correctness of the final value, including wrap past 12;
- the exact latency per operand;
- the handling of operands 0 and 1;
- the fact that a start dropped mid-run leaves the answer and its timing unchanged.

// File: rtl/fact_pkg.sv
package fact_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_MUL  = 3'd1,
    S_SUB  = 3'd2,
    S_CMP  = 3'd3,
    S_DONE = 3'd4
  } fact_state_t;

  // operation select: 1 subtract, 0 multiply
  localparam logic OP_MUL = 1'b0;
  localparam logic OP_SUB = 1'b1;
  // write select
  localparam logic WR_ACC = 1'b0;
  localparam logic WR_CNT = 1'b1;
  // operand selects
  localparam logic A_ACC = 1'b0;
  localparam logic A_CNT = 1'b1;
  localparam logic B_CNT = 1'b0;
  localparam logic B_ONE = 1'b1;

  typedef struct packed {
    logic load;
    logic aSel;
    logic bSel;
    logic opSel;
    logic wSel;
    logic wEn;
  } fact_ctrl_t;

endpackage

// File: rtl/fact_datapath.sv
module fact_datapath
  import fact_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  fact_ctrl_t       ctrl,
  input  logic [WIDTH-1:0] n,
  output logic [WIDTH-1:0] acc,
  output logic             cntLeOne
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt;
  logic [WIDTH-1:0] aOp;
  logic [WIDTH-1:0] bOp;
  logic [WIDTH-1:0] aluOut;

  always_comb begin
    aOp = (ctrl.aSel == A_CNT) ? cnt : acc;
    bOp = (ctrl.bSel == B_ONE) ? ONE : cnt;
    if (ctrl.opSel == OP_SUB) aluOut = aOp - bOp;
    else                      aluOut = aOp * bOp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
      cnt <= '0;
    end else if (ctrl.load) begin
      acc <= ONE;
      cnt <= n;
    end else if (ctrl.wEn) begin
      if (ctrl.wSel == WR_CNT) cnt <= aluOut;
      else                     acc <= aluOut;
    end
  end

  assign cntLeOne = (cnt <= ONE);

  // R3: accepted start initialises both registers
  p_load_init_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> (acc == ONE) && (cnt == $past(n)));

  // R6: subtract step lowers the counter by exactly one, accumulator untouched
  p_sub_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.wEn && !ctrl.load && ctrl.opSel == OP_SUB && ctrl.wSel == WR_CNT
     && ctrl.bSel == B_ONE && ctrl.aSel == A_CNT)
    |=> (cnt == $past(cnt) - ONE) && $stable(acc));

  // R6: multiply step leaves the counter unchanged
  p_mul_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.wEn && !ctrl.load && ctrl.opSel == OP_MUL && ctrl.wSel == WR_ACC)
    |=> $stable(cnt));

endmodule

// File: rtl/fact_control.sv
module fact_control
  import fact_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       cntLeOne,
  output fact_ctrl_t ctrl,
  output logic       done
);

  fact_state_t state, nextState;
  logic        accept;

  assign accept = start && (state == S_IDLE || state == S_DONE);

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE:  if (accept) nextState = S_CMP;
      S_MUL:   nextState = S_SUB;
      S_SUB:   nextState = S_CMP;
      S_CMP:   nextState = cntLeOne ? S_DONE : S_MUL;
      S_DONE:  if (accept) nextState = S_CMP;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctrl       = '0;
    ctrl.load  = accept;
    case (state)
      S_MUL: begin
        ctrl.aSel  = A_ACC;
        ctrl.bSel  = B_CNT;
        ctrl.opSel = OP_MUL;
        ctrl.wSel  = WR_ACC;
        ctrl.wEn   = 1'b1;
      end
      S_SUB: begin
        ctrl.aSel  = A_CNT;
        ctrl.bSel  = B_ONE;
        ctrl.opSel = OP_SUB;
        ctrl.wSel  = WR_CNT;
        ctrl.wEn   = 1'b1;
      end
      default: ;
    endcase
  end

  assign done = (state == S_DONE);

  // R5: loop order
  p_mul_then_sub_r5: assert property (@(posedge clk) disable iff (!rstN)
    state == S_MUL |=> state == S_SUB);
  p_sub_then_cmp_r5: assert property (@(posedge clk) disable iff (!rstN)
    state == S_SUB |=> state == S_CMP);
  p_cmp_loops_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CMP && !cntLeOne) |=> state == S_MUL);
  // R8: busy states never take a load
  p_busy_no_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_MUL || state == S_SUB || state == S_CMP) |-> !ctrl.load);

endmodule

// File: rtl/fact_engine.sv
module fact_engine
  import fact_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] n,
  output logic [WIDTH-1:0] result,
  output logic             done
);

  fact_ctrl_t ctrl;
  logic       cntLeOne;

  fact_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .cntLeOne (cntLeOne),
    .ctrl     (ctrl),
    .done     (done)
  );

  fact_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .n        (n),
    .acc      (result),
    .cntLeOne (cntLeOne)
  );

  // R7: finished output holds until a new start
  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done && $stable(result));

endmodule

// File: tb/sim_fact_engine.sv
module sim_fact_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] n = '0;
  logic [31:0] result;
  logic        done;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  fact_engine u0 (
    .clk(clk), .rstN(rstN), .start(start), .n(n), .result(result), .done(done)
  );

  function automatic logic [31:0] refFact(input int unsigned k);
    logic [31:0] p = 32'd1;
    for (int i = 2; i <= int'(k); i++) p = p * 32'(i);
    return p;
  endfunction

  function automatic int refLat(input int unsigned k);
    return (k == 0) ? 2 : 3 * int'(k) - 1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // run one computation; optional stray start on cycle strayAt (0 = none)
  task automatic runOne(input int unsigned k, input int strayAt, input string req);
    int lat;
    @(negedge clk);
    n = k;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 2000) begin
      if (lat == strayAt) begin
        start = 1'b1;
        n = 32'd3;
      end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    check({req, " latency R11"}, 32'(lat), 32'(refLat(k)));
    check({req, " result R1"}, result, refFact(k));
  endtask

  initial begin
    int unsigned seedDummy;
    seedDummy = $urandom(32'd2024);
    // R2: reset state
    #3;
    check("R2 done in reset", {31'd0, done}, 32'd0);
    check("R2 result in reset", result, 32'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 done after reset", {31'd0, done}, 32'd0);
    check("R2 result after reset", result, 32'd0);

    runOne(0, 0, "R4 n=0");
    check("R4 n=0 value", result, 32'd1);
    runOne(1, 0, "R4 n=1");
    check("R4 n=1 value", result, 32'd1);
    // R10, exercises R3 load, R5 loop order and R6 operations
    runOne(5, 0, "R10 R3 R5 R6 n=5");
    check("R10 n=5 value", result, 32'd120);

    // R7: hold while idle after done
    repeat (10) @(negedge clk);
    check("R7 done held", {31'd0, done}, 32'd1);
    check("R7 result held", result, 32'd120);

    runOne(12, 0, "R1 n=12");
    runOne(13, 0, "R9 n=13");
    check("R9 wrap value", result, 32'd1932053504);

    // R8: stray start mid-run ignored
    runOne(6, 4, "R8 n=6 stray start");
    check("R8 n=6 value", result, 32'd720);
    runOne(9, 11, "R8 n=9 stray start");

    for (int i = 0; i < 24; i++) begin
      runOne($urandom_range(40, 0), 0, "R1 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule